// File: doc/BRIEF.md
# Bus master transfer width sequencer

This block sits between an internal slave port and a simplified PCI-style master data path. It takes one request at a time and turns it into data phases with an address, data lanes, byte enables and a 64-bit request flag. A request is either a single beat of one to eight bytes at any byte address, or a four-beat burst that moves a whole 32-byte line.

A single beat becomes one or two 32-bit data phases, depending on whether its bytes stay inside one 4-byte word. A burst is offered at 64 bits per phase when the 64-bit enable input is set. If the target leaves its 64-bit acknowledge low on the first completed phase, only the lower word of that phase counts as moved. The rest of the line then goes out as 32-bit phases. A one-cycle done pulse follows the last phase, and the block takes no new request until it is idle again.

Top module: `xfer_width_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `ph_valid`, `ph_req64` and `done` are 0.
- R2: A single-beat request (`req_burst`=0, `req_size` = byte count 1..8, request byte k held in `req_data[8k+7:8k]` and addressed at `req_addr`+k) whose bytes lie in one 4-byte word gives exactly one phase. That phase has the word-aligned address and 32-bit data, with byte lane j (`ph_data[8j+7:8j]`, `ph_be[j]`) carrying address word+j. The enables cover exactly the requested bytes, and the unrequested lanes and the upper four enables are 0.
- R3: A single-beat request whose byte range crosses a 4-byte boundary gives exactly two 32-bit phases. The lower word goes first, and each phase enables only its own requested bytes.
- R4: A burst (`req_burst`=1; `req_addr[4:0]` is ignored; line byte k is in `req_data[8k+7:8k]`) with `en64`=1 and `ph_ack64`=1 on the first phase gives four phases. These are at line base +0, +8, +16, +24, each carrying 64 bits with `ph_be`=8'hFF and `ph_req64`=1.
- R5: If a 64-bit burst's first phase completes with `ph_ack64`=0, that phase counts as the lower word only. Seven 32-bit phases follow for words 1..7, in ascending order, each with `ph_be`=8'h0F and `ph_req64`=0.
- R6: `ph_ack64` is sampled only on the first phase of a burst. A later change neither narrows a burst that was accepted as 64-bit nor widens one that has fallen back.
- R7: A burst with `en64`=0 gives eight 32-bit phases at base +0..+28 with `ph_req64` never asserted.
- R8: While `ph_valid`=1 and `ph_ready`=0, the presented phase (address, data, enables, `ph_req64`) holds unchanged. A phase completes on a cycle with both high.
- R9: `done` is high for exactly one cycle, the cycle right after the final phase completes, and the block is idle in that cycle.
- R10: A request is taken only when `req_ready`=1. `req_valid` while busy has no effect on the phases of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, request will be taken |
| req_burst | input | 1 | 1 = four-beat line burst, 0 = single beat |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 4 | Byte count of a single beat (1..8) |
| req_data | input | 256 | Request bytes, byte k at bits 8k+7:8k |
| en64 | input | 1 | Allow 64-bit phases for bursts |
| ph_valid | output | 1 | A data phase is presented |
| ph_ready | input | 1 | Target completes the presented phase |
| ph_ack64 | input | 1 | Target accepts 64-bit width (first phase only) |
| ph_addr | output | ADDR_W | Phase address (4- or 8-byte aligned) |
| ph_data | output | 64 | Phase data lanes |
| ph_be | output | 8 | Active-high byte enables |
| ph_req64 | output | 1 | Phase offered at 64 bits |
| done | output | 1 | One-cycle pulse after the final phase |

## Verification
The assertions assume that single-beat requests are legal. That means a byte count from 1 to 8 that touches at most two 4-byte words, so the low two address bits plus the count never exceed 8. One assertion states this assumption at the request port. The directed stimulus only issues such requests, and puts the bursts at unaligned addresses to show that the low line bits are dropped. The acknowledge input is driven for whole bursts, including patterns that change after the first phase. Target stalls are inserted at varied cycles, so phase holding is checked together with every width mode.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int WORD_B     = 4;
    localparam int DWORD_B    = 8;
    localparam int LINE_B     = 32;
    localparam int LINE_WORDS = LINE_B / WORD_B;
    localparam int WIX_W      = $clog2(LINE_WORDS);
    localparam int LINE_SH    = $clog2(LINE_B);
    localparam int SIZE_W     = 4;
    localparam int LINE_BITS  = LINE_B * 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_WIDE   = 2'd2,
        ST_NARROW = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [1:0]        lo;
    } single_meta_t;

    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  be;
    } lanes_t;

    // True when a single beat spills into the next 32-bit word
    function automatic logic single_spans_two(logic [1:0] lo, logic [SIZE_W-1:0] size);
        return (5'(lo) + 5'(size)) > 5'(WORD_B);
    endfunction

    // Byte enables for word w (0 or 1) of a single beat
    function automatic logic [3:0] single_be(logic [1:0] lo, logic [SIZE_W-1:0] size, logic w);
        logic [3:0] be;
        int k;
        for (int j = 0; j < WORD_B; j++) begin
            k = WORD_B * int'(w) + j - int'(lo);
            be[j] = (k >= 0) && (k < int'(size));
        end
        return be;
    endfunction

    // Lane data for word w of a single beat; unrequested lanes are zero
    function automatic logic [31:0] single_lanes(logic [63:0] bytes, logic [1:0] lo,
                                                 logic [SIZE_W-1:0] size, logic w);
        logic [31:0] d;
        int k;
        d = '0;
        for (int j = 0; j < WORD_B; j++) begin
            k = WORD_B * int'(w) + j - int'(lo);
            if (k >= 0 && k < int'(size) && k < DWORD_B)
                d[8*j +: 8] = bytes[8*k +: 8];
        end
        return d;
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_burst,
    input  single_meta_t         req_meta,
    input  logic                 en64,
    input  logic                 ph_ready,
    input  logic                 ph_ack64,
    output logic                 req_ready,
    output logic                 accept,
    output seq_st_e              st,
    output logic [WIX_W-1:0]     widx,
    output logic                 first,
    output logic                 done
);

    logic two_words;
    logic xfer;
    logic last;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign xfer      = (st != ST_IDLE) && ph_ready;

    always_comb begin
        unique case (st)
            ST_SINGLE: last = (widx == WIX_W'(two_words));
            ST_WIDE:   last = (widx == WIX_W'(LINE_WORDS - 2));
            ST_NARROW: last = (widx == WIX_W'(LINE_WORDS - 1));
            default:   last = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            widx      <= '0;
            first     <= 1'b0;
            two_words <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= xfer && last;
            if (accept) begin
                widx      <= '0;
                first     <= 1'b1;
                two_words <= single_spans_two(req_meta.lo, req_meta.size);
                if (!req_burst)
                    st <= ST_SINGLE;
                else if (en64)
                    st <= ST_WIDE;
                else
                    st <= ST_NARROW;
            end else if (xfer) begin
                first <= 1'b0;
                if (last) begin
                    st <= ST_IDLE;
                end else if (st == ST_WIDE) begin
                    if (first && !ph_ack64) begin
                        st   <= ST_NARROW;
                        widx <= widx + WIX_W'(1);
                    end else begin
                        widx <= widx + WIX_W'(2);
                    end
                end else begin
                    widx <= widx + WIX_W'(1);
                end
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && !ph_ready) |=> ($stable(widx) && $stable(st))); // R8

    AST_NO_REWIDEN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NARROW) |=> (st != ST_WIDE)); // R6

    AST_WIDE_STAYS_WIDE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WIDE && !first) |=> (st == ST_WIDE || st == ST_IDLE)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready); // R9

endmodule

// File: rtl/seq_format.sv
module seq_format
    import seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  seq_st_e                st,
    input  logic [WIX_W-1:0]       widx,
    input  logic [ADDR_W-1:0]      base,
    input  single_meta_t           meta,
    input  logic [LINE_BITS-1:0]   line,
    output logic [ADDR_W-1:0]      ph_addr,
    output lanes_t                 lanes
);

    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0]   single_word;
    logic [ADDR_W-1:0] line_addr;
    logic [1:0]        dw_idx;

    assign single_word = base[ADDR_W-1:2] + WA_W'(widx[0]);
    assign line_addr   = {base[ADDR_W-1:LINE_SH], widx, 2'b00};
    assign dw_idx      = widx[WIX_W-1:1];

    always_comb begin
        ph_addr = '0;
        lanes   = '0;
        unique case (st)
            ST_SINGLE: begin
                ph_addr       = {single_word, 2'b00};
                lanes.data    = {32'b0, single_lanes(line[63:0], meta.lo, meta.size, widx[0])};
                lanes.be      = {4'b0, single_be(meta.lo, meta.size, widx[0])};
            end
            ST_WIDE: begin
                ph_addr       = line_addr;
                lanes.data    = line[64*dw_idx +: 64];
                lanes.be      = 8'hFF;
            end
            ST_NARROW: begin
                ph_addr       = line_addr;
                lanes.data    = {32'b0, line[32*widx +: 32]};
                lanes.be      = 8'h0F;
            end
            default: begin
                ph_addr = '0;
                lanes   = '0;
            end
        endcase
    end

endmodule

// File: rtl/xfer_width_seq.sv
module xfer_width_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_burst,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [SIZE_W-1:0]      req_size,
    input  logic [LINE_BITS-1:0]   req_data,
    input  logic                   en64,
    output logic                   ph_valid,
    input  logic                   ph_ready,
    input  logic                   ph_ack64,
    output logic [ADDR_W-1:0]      ph_addr,
    output logic [63:0]            ph_data,
    output logic [7:0]             ph_be,
    output logic                   ph_req64,
    output logic                   done
);

    seq_st_e              st;
    logic [WIX_W-1:0]     widx;
    logic                 first;
    logic                 accept;
    single_meta_t         in_meta;
    single_meta_t         cap_meta;
    logic [ADDR_W-1:0]    cap_addr;
    logic [LINE_BITS-1:0] cap_data;
    lanes_t               lanes;

    assign in_meta = '{size: req_size, lo: req_addr[1:0]};

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_burst (req_burst),
        .req_meta  (in_meta),
        .en64      (en64),
        .ph_ready  (ph_ready),
        .ph_ack64  (ph_ack64),
        .req_ready (req_ready),
        .accept    (accept),
        .st        (st),
        .widx      (widx),
        .first     (first),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_meta <= '0;
            cap_data <= '0;
        end else if (accept) begin
            cap_addr <= req_addr;
            cap_meta <= in_meta;
            cap_data <= req_data;
        end
    end

    seq_format #(.ADDR_W(ADDR_W)) u_fmt (
        .st      (st),
        .widx    (widx),
        .base    (cap_addr),
        .meta    (cap_meta),
        .line    (cap_data),
        .ph_addr (ph_addr),
        .lanes   (lanes)
    );

    assign ph_valid = (st != ST_IDLE);
    assign ph_req64 = (st == ST_WIDE);
    assign ph_data  = lanes.data;
    assign ph_be    = lanes.be;

    AST_SINGLE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_burst) |->
        (req_size != '0 && req_size <= SIZE_W'(DWORD_B) &&
         (5'(req_addr[1:0]) + 5'(req_size)) <= 5'(DWORD_B))); // R2

    AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        ph_valid |-> (ph_be != 8'h00)); // R2

    AST_NARROW_UPPER_OFF: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && !ph_req64) |-> (ph_be[7:4] == 4'h0)); // R3

    AST_WIDE_FULL: assert property (@(posedge clk) disable iff (rst)
        ph_req64 |-> (ph_be == 8'hFF && ph_addr[2:0] == 3'b000)); // R4

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> ($stable(cap_addr) && $stable(cap_data))); // R10

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && !ph_ready) |=> ($stable(ph_addr) && $stable(ph_data) &&
                                     $stable(ph_be) && $stable(ph_req64))); // R8

endmodule

// File: tb/tb_xfer_width_seq.sv
module tb_xfer_width_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic           clk = 1'b0;
    logic           rst;
    logic           req_valid, req_ready, req_burst, en64;
    logic [AW-1:0]  req_addr;
    logic [3:0]     req_size;
    logic [255:0]   req_data;
    logic           ph_valid, ph_ready, ph_ack64, ph_req64, done;
    logic [AW-1:0]  ph_addr;
    logic [63:0]    ph_data;
    logic [7:0]     ph_be;

    int n_cmp = 0;
    int n_bad = 0;

    logic [AW-1:0] e_addr [8];
    logic [63:0]   e_data [8];
    logic [7:0]    e_be   [8];
    logic          e_r64  [8];
    int            e_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_width_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_burst(req_burst),
        .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
        .en64(en64),
        .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_ack64(ph_ack64),
        .ph_addr(ph_addr), .ph_data(ph_data), .ph_be(ph_be),
        .ph_req64(ph_req64), .done(done)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] make_line(input int seed);
        logic [255:0] v;
        for (int k = 0; k < 32; k++) v[8*k +: 8] = 8'(seed * 7 + k * 13 + 1);
        return v;
    endfunction

    task automatic plan_single(input logic [AW-1:0] a, input int sz, input logic [255:0] d);
        logic [AW-1:0] fw;
        int idx, lane;
        fw = a >> 2;
        for (int i = 0; i < 8; i++) begin
            e_data[i] = '0; e_be[i] = '0; e_r64[i] = 1'b0; e_addr[i] = '0;
        end
        e_n = 1;
        for (int k = 0; k < sz; k++) begin
            idx  = int'(((a + AW'(k)) >> 2) - fw);
            lane = int'((a + AW'(k)) & 32'h3);
            e_be[idx][lane] = 1'b1;
            e_data[idx][8*lane +: 8] = d[8*k +: 8];
            if (idx + 1 > e_n) e_n = idx + 1;
        end
        for (int i = 0; i < 2; i++) e_addr[i] = (fw + AW'(i)) << 2;
    endtask

    // mode: 0 = 64-bit accepted, 1 = fallback after first phase, 2 = 32-bit only
    task automatic plan_burst(input logic [AW-1:0] a, input logic [255:0] d, input int mode);
        logic [AW-1:0] b;
        b = a & ~32'h1F;
        if (mode == 0) begin
            e_n = 4;
            for (int i = 0; i < 4; i++) begin
                e_addr[i] = b + AW'(8*i); e_data[i] = d[64*i +: 64];
                e_be[i] = 8'hFF; e_r64[i] = 1'b1;
            end
        end else begin
            e_n = 8;
            for (int i = 0; i < 8; i++) begin
                e_addr[i] = b + AW'(4*i); e_data[i] = {32'b0, d[32*i +: 32]};
                e_be[i] = 8'h0F; e_r64[i] = 1'b0;
            end
            if (mode == 1) begin
                e_data[0] = d[63:0]; e_be[0] = 8'hFF; e_r64[0] = 1'b1;
            end
        end
    endtask

    // ackmode: 0 never, 1 always, 2 first phase only, 3 all but first
    task automatic run(input string req, input logic burst, input logic [AW-1:0] a,
                       input int sz, input logic [255:0] d, input logic e64,
                       input int ackmode, input logic [7:0] stall, input logic probe);
        int i, cyc;
        @(negedge clk);
        chk(req_ready, "R10", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_burst = burst; req_addr = a; req_size = 4'(sz);
        req_data = d; en64 = e64;
        @(negedge clk);
        if (probe) begin
            req_valid = 1'b1; req_burst = 1'b0; req_addr = 32'h0000_0F00;
            req_size = 4'd1; req_data = ~d;
        end else begin
            req_valid = 1'b0;
        end
        i = 0; cyc = 0;
        while (i < e_n && cyc < 200) begin
            ph_ready = ~stall[cyc % 8];
            case (ackmode)
                0: ph_ack64 = 1'b0;
                1: ph_ack64 = 1'b1;
                2: ph_ack64 = (i == 0);
                default: ph_ack64 = (i != 0);
            endcase
            #1;
            if (probe && cyc == 0)
                chk(!req_ready, "R10", "ready while busy", 64'(req_ready), 64'd0);
            chk(ph_valid, req, "phase valid", 64'(ph_valid), 64'd1);
            chk(ph_addr == e_addr[i], req, $sformatf("addr ph%0d", i), 64'(ph_addr), 64'(e_addr[i]));
            chk(ph_data == e_data[i], req, $sformatf("data ph%0d", i), ph_data, e_data[i]);
            chk(ph_be == e_be[i], req, $sformatf("be ph%0d", i), 64'(ph_be), 64'(e_be[i]));
            chk(ph_req64 == e_r64[i], req, $sformatf("req64 ph%0d", i), 64'(ph_req64), 64'(e_r64[i]));
            if (ph_ready) i++;
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end
        ph_ready = 1'b0; ph_ack64 = 1'b0;
        #1;
        chk(done, "R9", "done after last phase", 64'(done), 64'd1);
        chk(!ph_valid, "R9", "no phase after last", 64'(ph_valid), 64'd0);
        @(negedge clk); #1;
        chk(!done, "R9", "done single cycle", 64'(done), 64'd0);
        chk(req_ready, "R9", "idle after done", 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready, "R1", "ready", 64'(req_ready), 64'd1);
        chk(!ph_valid, "R1", "ph_valid", 64'(ph_valid), 64'd0);
        chk(!ph_req64, "R1", "ph_req64", 64'(ph_req64), 64'd0);
        chk(!done, "R1", "done", 64'(done), 64'd0);
    endtask

    task automatic t_single(input string req, input logic [AW-1:0] a, input int sz,
                            input int seed, input logic [7:0] stall, input int exp_n);
        logic [255:0] d;
        d = make_line(seed);
        plan_single(a, sz, d);
        chk(e_n == exp_n, req, "planned phase count", 64'(e_n), 64'(exp_n));
        run(req, 1'b0, a, sz, d, 1'b1, 1, stall, 1'b0);
    endtask

    task automatic t_burst(input string req, input logic [AW-1:0] a, input int seed,
                           input logic e64, input int ackmode, input int pmode,
                           input logic [7:0] stall, input logic probe);
        logic [255:0] d;
        d = make_line(seed);
        plan_burst(a, d, pmode);
        run(req, 1'b1, a, 0, d, e64, ackmode, stall, probe);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        req_valid = 0; req_burst = 0; req_addr = '0; req_size = '0; req_data = '0;
        en64 = 0; ph_ready = 0; ph_ack64 = 0;
        t_reset();                                                                    // R1
        t_single("R2", 32'h0000_0100, 4, 1, 8'h00, 1);                                // aligned word
        t_single("R2", 32'h0000_0103, 1, 2, 8'h00, 1);                                // top lane only
        t_single("R2", 32'h0000_0205, 3, 3, 8'h01, 1);                                // upper lanes
        t_single("R3", 32'h0000_0102, 4, 4, 8'h00, 2);                                // straddle
        t_single("R3", 32'h0000_0200, 8, 5, 8'h05, 2);                                // full dword, stalls R8
        t_single("R3", 32'h0000_0303, 2, 6, 8'h00, 2);                                // two bytes across
        t_burst("R4", 32'h1000_0013, 7, 1'b1, 1, 0, 8'h00, 1'b0);                     // 64-bit line
        t_burst("R8", 32'h1000_0040, 8, 1'b1, 1, 0, 8'h6B, 1'b0);                     // 64-bit with stalls
        t_burst("R5", 32'h2000_0020, 9, 1'b1, 0, 1, 8'h00, 1'b0);                     // fallback
        t_burst("R5", 32'h2000_0060, 10, 1'b1, 0, 1, 8'h12, 1'b0);                    // fallback, stalls
        t_burst("R6", 32'h3000_0000, 11, 1'b1, 2, 0, 8'h00, 1'b0);                    // ack drops later
        t_burst("R6", 32'h3000_0080, 12, 1'b1, 3, 1, 8'h04, 1'b0);                    // ack rises later
        t_burst("R7", 32'h4000_00E7, 13, 1'b0, 1, 2, 8'h00, 1'b0);                    // 32-bit only
        t_burst("R10", 32'h5000_0020, 14, 1'b1, 1, 0, 8'h00, 1'b1);                   // busy probe
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule